// File: doc/BRIEF.md
# Multi-Lane Next-Line Prefetch Arbiter

This block keeps one small next-line prefetch engine for each requester and presents all of them through a single pull port. A requester reports each cache access with its lane index, the byte address and a flag saying whether the access missed. A miss loads that lane with the cache lines that follow the missed address, up to a fixed distance ahead. Hits leave the lane alone.

The shared output shows one candidate at a time: the prefetch address together with the index of the lane that produced it. A consumer takes a candidate by raising the ready signal while the valid signal is high. Exactly one candidate leaves per accepted pull. When several lanes have work, a round-robin pointer spreads the pulls across them. The block does not issue memory requests, and it does not remove duplicate addresses across lanes.

Top module: `nl_prefetch_arbiter`

## Requirements
- R1: While reset is asserted, and right after it is released, `pf_valid` is low.
- R2: A miss report at byte address A on lane L makes lane L offer A+64 and then A+128. Each is tagged with L on `pf_lane`. After those two are taken, the lane offers nothing more.
- R3: A report with `rpt_miss` low creates no candidate. It also leaves the candidates a lane already holds unchanged.
- R4: `pf_valid` high with `pf_ready` high takes exactly one candidate on that clock edge. While `pf_ready` is low and no report arrives, `pf_addr` and `pf_lane` hold steady.
- R5: After lane g is served, the next candidate comes from the first lane with pending work, searching cyclically from g+1. Lanes with nothing pending are skipped.
- R6: A new miss on a lane discards that lane's candidates that have not yet been issued. It replaces them with the two lines that follow the new address.
- R7: `pf_lane` always names a lane below the lane count (0, 1 or 2 by default) and identifies the lane whose report produced the address.
- R8: A report whose lane index is not below the lane count (3 by default) is ignored.
- R9: Prefetch addresses are computed modulo 2^ADDR_W, so a miss at 0xFFFFFFC0 offers 0x00000000 and then 0x00000040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | An access report is present this cycle |
| rpt_lane | input | LW | Lane index of the report |
| rpt_addr | input | ADDR_W | Byte address of the reported access |
| rpt_miss | input | 1 | 1 = the access missed, 0 = hit |
| pf_valid | output | 1 | A prefetch candidate is offered |
| pf_ready | input | 1 | Consumer takes the offered candidate |
| pf_addr | output | ADDR_W | Offered prefetch address |
| pf_lane | output | LW | Lane that produced the offered address |

## Verification
The hardest situation to reach is the round-robin pointer sitting at an empty lane while the lanes on either side both hold work. That is the only case where the skip rule of R5 shows, rather than plain alternation. The bench first drives earlier scenarios whose pulls leave the pointer at a known lane. It then loads only the lanes around that empty lane, so the skip and the wrap back to lane 0 can be seen in the sequence of `pf_lane` values.

// File: rtl/nl_prefetch_arbiter.sv
module nl_prefetch_arbiter #(
  parameter int LANES      = 3,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int AHEAD      = 2,
  parameter int LW         = (LANES > 1) ? $clog2(LANES) + ((LANES & (LANES - 1)) == 0 ? 1 : 0) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid,
  input  logic [LW-1:0]     rpt_lane,
  input  logic [ADDR_W-1:0] rpt_addr,
  input  logic              rpt_miss,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [LW-1:0]     pf_lane
);
  localparam int CW = $clog2(AHEAD + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);

  logic [ADDR_W-1:0] nxt_q  [LANES];
  logic [CW-1:0]     left_q [LANES];
  logic [LANES-1:0]  pend;
  logic [LW-1:0]     ptr_q;
  logic [LW-1:0]     gnt;
  logic              fire;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int k = 0; k < LANES; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % LANES;
      if (!found && pend[idx]) begin
        found = 1'b1;
        gnt   = LW'(idx);
      end
    end
  end

  assign pf_valid = |pend;
  assign pf_addr  = nxt_q[gnt];
  assign pf_lane  = gnt;
  assign fire     = pf_valid && pf_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic load, take;
    assign load    = rpt_valid && rpt_miss && (rpt_lane == LW'(i));
    assign take    = fire && (gnt == LW'(i));
    assign pend[i] = (left_q[i] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nxt_q[i]  <= '0;
        left_q[i] <= '0;
      end else if (load) begin
        nxt_q[i]  <= rpt_addr + STEP;
        left_q[i] <= CW'(AHEAD);
      end else if (take) begin
        nxt_q[i]  <= nxt_q[i] + STEP;
        left_q[i] <= left_q[i] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (fire) ptr_q <= (gnt == LW'(LANES - 1)) ? '0 : gnt + LW'(1);
  end
endmodule

module nl_prefetch_arbiter_chk #(
  parameter int LANES  = 3,
  parameter int ADDR_W = 32,
  parameter int LW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rpt_valid,
  input logic [LW-1:0]     rpt_lane,
  input logic [ADDR_W-1:0] rpt_addr,
  input logic              rpt_miss,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [LW-1:0]     pf_lane
);
  localparam logic [LW:0] NLANE = (LW + 1)'(LANES);

  always @(posedge clk) begin
    if (!rst_n) a_r1_idle_in_reset: assert (!pf_valid);
  end

  a_r2_miss_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && rpt_miss && ({1'b0, rpt_lane} < NLANE) |=> pf_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid && !(rpt_valid && rpt_miss) |=> !pf_valid);

  a_r4_hold_without_pull: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !rpt_valid |=> pf_valid && $stable(pf_addr) && $stable(pf_lane));

  a_r7_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> ({1'b0, pf_lane} < NLANE));
endmodule

bind nl_prefetch_arbiter nl_prefetch_arbiter_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_lane(rpt_lane),
  .rpt_addr(rpt_addr), .rpt_miss(rpt_miss), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_lane(pf_lane)
);

// File: tb/nl_prefetch_arbiter_bench.sv
module nl_prefetch_arbiter_bench;
  localparam int LW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rpt_valid = 1'b0, rpt_miss = 1'b0, pf_ready = 1'b0;
  logic [LW-1:0] rpt_lane = '0;
  logic [31:0] rpt_addr = '0;
  logic pf_valid;
  logic [31:0] pf_addr;
  logic [LW-1:0] pf_lane;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  nl_prefetch_arbiter u_nl_prefetch_arbiter (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_lane(rpt_lane),
    .rpt_addr(rpt_addr), .rpt_miss(rpt_miss), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_lane(pf_lane)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report(input int lane, input logic [31:0] a, input bit miss);
    rpt_valid = 1'b1; rpt_lane = LW'(lane); rpt_addr = a; rpt_miss = miss;
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  task automatic pull(input logic [31:0] ea, input int el, input string req);
    chk(pf_valid, req, 64'(pf_valid), 64'd1);
    chk(pf_addr == ea && pf_lane == LW'(el), req, {pf_addr, 30'd0, pf_lane}, {ea, 30'd0, LW'(el)});
    pf_ready = 1'b1;
    @(negedge clk);
    pf_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    chk(!pf_valid, req, 64'(pf_valid), 64'd0);
  endtask

  task automatic t_reset();
    expect_empty("R1 in reset");
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    expect_empty("R1 after reset");
  endtask

  task automatic t_basic();
    report(1, 32'h9000_0000, 1);
    pull(32'h9000_0040, 1, "R2 first line");
    pull(32'h9000_0080, 1, "R2 second line");
    expect_empty("R2 drained");
  endtask

  task automatic t_hit();
    report(0, 32'h0000_1000, 0);
    expect_empty("R3 hit makes nothing");
    report(2, 32'h0000_2000, 1);
    pull(32'h0000_2040, 2, "R3 setup");
    report(2, 32'h0000_5000, 0);
    pull(32'h0000_2080, 2, "R3 hit keeps candidates");
    expect_empty("R3 drained");
  endtask

  task automatic t_hold();
    report(0, 32'h0000_3000, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(pf_valid && pf_addr == 32'h0000_3040, "R4 hold", 64'(pf_addr), 64'h3040);
    end
    pull(32'h0000_3040, 0, "R4 one per pull");
    pull(32'h0000_3080, 0, "R4 next");
    expect_empty("R4 drained");
  endtask

  task automatic t_rr();
    report(0, 32'h4000_0000, 1);
    report(1, 32'h5000_0000, 1);
    report(2, 32'h6000_0000, 1);
    pull(32'h5000_0040, 1, "R5 R7 rr a");
    pull(32'h6000_0040, 2, "R5 R7 rr b");
    pull(32'h4000_0040, 0, "R5 R7 rr c");
    pull(32'h5000_0080, 1, "R5 R7 rr d");
    pull(32'h6000_0080, 2, "R5 R7 rr e");
    pull(32'h4000_0080, 0, "R5 R7 rr f");
    expect_empty("R5 drained");
    report(0, 32'h0000_7000, 1);
    report(2, 32'h0000_8000, 1);
    pull(32'h0000_8040, 2, "R5 skip empty lane");
    pull(32'h0000_7040, 0, "R5 wrap");
    pull(32'h0000_8080, 2, "R5 skip again");
    pull(32'h0000_7080, 0, "R5 last");
    expect_empty("R5 drained 2");
  endtask

  task automatic t_replace();
    report(1, 32'h0000_A000, 1);
    pull(32'h0000_A040, 1, "R6 before");
    report(1, 32'h0000_B000, 1);
    pull(32'h0000_B040, 1, "R6 replaced first");
    pull(32'h0000_B080, 1, "R6 replaced second");
    expect_empty("R6 old gone");
  endtask

  task automatic t_badlane();
    report(3, 32'h0000_C000, 1);
    expect_empty("R8 lane 3 ignored");
  endtask

  task automatic t_wrap();
    report(0, 32'hFFFF_FFC0, 1);
    pull(32'h0000_0000, 0, "R9 wrap first");
    pull(32'h0000_0040, 0, "R9 wrap second");
    expect_empty("R9 drained");
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_hit();
    t_hold();
    t_rr();
    t_replace();
    t_badlane();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule